// File: doc/BRIEF.md
# Address Sequence Command Detector

This block sits beside a memory front end and snoops every host access. A command is hidden in the stream as six back-to-back reads. Five fixed prefix addresses come first. A sixth address then picks one of four commands: save to non-volatile storage, restore from it, turn the power-loss auto-save off, or turn it on. When the whole sequence matches, the block raises a one-cycle pulse on the output for that command. Carrying out the command is left to other logic.

Any access that breaks the pattern abandons the sequence. This covers a write, a read of the wrong address, or a read at the wrong step. If the breaking read is itself the first prefix address, it counts as the start of a new attempt. During the sixth read of a save or restore command, a combinational flag tells the front end to float its data outputs. While an external inhibit input is high, accesses are ignored and the detector is held at idle.

Top module: `asq_cmd_detect`

## Requirements
- R1: The five prefix reads (low 14 bits 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, in that order), followed by a valid sixth read, produce exactly one output pulse. The pulse appears in the clock cycle after the sixth access is sampled.
- R2: The sixth address, in its low 14 bits, selects the output: 0x0FC0 drives `cmd_store`, 0x0C63 drives `cmd_recall`, 0x0B45 drives `cmd_autosave_off` and 0x0B46 drives `cmd_autosave_on`. At most one of the four is high in any cycle.
- R3: Address bits 16 down to 14 have no effect on matching.
- R4: A write (`acc_wr`=1 with `acc_vld`=1) at any step abandons the sequence, and no command follows.
- R5: A read that does not match the expected step abandons the sequence. If that read matches the first prefix address, progress restarts as if the first step had just been seen.
- R6: After a command pulse the detector is idle. Repeating only the sixth read gives no further pulse.
- R7: `dq_float` is high in the same cycle as a sixth read carrying the save or restore code. It is low for the two auto-save codes and for all other accesses.
- R8: While `inhibit` is 1, accesses are ignored, no pulse or float is produced, and progress returns to idle.
- R9: After reset all outputs are 0 and the detector is idle.
- R10: Cycles with `acc_vld`=0 leave progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_vld | input | 1 | An access is presented this cycle |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 17 | Access address |
| inhibit | input | 1 | Busy: ignore accesses and return to idle |
| cmd_store | output | 1 | One-cycle save command pulse |
| cmd_recall | output | 1 | One-cycle restore command pulse |
| cmd_autosave_off | output | 1 | One-cycle auto-save disable pulse |
| cmd_autosave_on | output | 1 | One-cycle auto-save enable pulse |
| dq_float | output | 1 | Float data outputs during this access |

## Verification
The bench aims at aborts caused by the first prefix address, which a design without restart would treat as a plain abort and so miss the command that follows. It also targets writes placed between the prefix reads, which a design that only compares addresses would let complete. It drives random high address bits, which would break matching in a design that compares all 17 bits. Idle gaps and inhibit bursts are placed mid-sequence to catch a counter that advances or keeps its progress when it should not. The float flag is checked against all four codes, so a design that also floats on the auto-save codes is exposed.

// File: rtl/asq_pkg.sv
package asq_pkg;
   localparam int unsigned PREFIX_LEN = 5;
   localparam int unsigned NUM_CMD    = 4;

   // bit positions of the command pulse vector
   typedef enum int unsigned {
      CMD_STORE  = 0,
      CMD_RECALL = 1,
      CMD_AS_OFF = 2,
      CMD_AS_ON  = 3
   } cmd_e;

   function automatic logic [15:0] prefix_code(input int unsigned idx);
      case (idx)
         0:       return 16'h4E38;
         1:       return 16'hB1C7;
         2:       return 16'h83E0;
         3:       return 16'h7C1F;
         default: return 16'h703F;
      endcase
   endfunction

   function automatic logic [15:0] cmd_code(input int unsigned idx);
      case (idx)
         CMD_STORE:  return 16'h0FC0;
         CMD_RECALL: return 16'h0C63;
         CMD_AS_OFF: return 16'h0B45;
         default:    return 16'h0B46;
      endcase
   endfunction

   function automatic logic cmd_floats(input int unsigned idx);
      return (idx == CMD_STORE) || (idx == CMD_RECALL);
   endfunction
endpackage

// File: rtl/asq_match.sv
module asq_match
   import asq_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned CMP_W  = 14,
   parameter int unsigned STEP_W = 3
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [STEP_W-1:0]  step,
   output logic               prefix_hit,
   output logic               first_hit,
   output logic [NUM_CMD-1:0] cmd_hit,
   output logic               float_hit
);
   logic [CMP_W-1:0]      key;
   logic [PREFIX_LEN-1:0] pre_vec;
   logic [NUM_CMD-1:0]    flt_vec;

   assign key = addr[CMP_W-1:0];

   for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_pre
      localparam logic [15:0] CODE = prefix_code(i);
      assign pre_vec[i] = (key == CODE[CMP_W-1:0]);
   end

   for (genvar c = 0; c < NUM_CMD; c++) begin : g_cmd
      localparam logic [15:0] CODE = cmd_code(c);
      assign cmd_hit[c] = (key == CODE[CMP_W-1:0]);
      if (cmd_floats(c)) begin : g_flt
         assign flt_vec[c] = cmd_hit[c];
      end else begin : g_noflt
         assign flt_vec[c] = 1'b0;
      end
   end

   always_comb begin
      prefix_hit = 1'b0;
      for (int i = 0; i < PREFIX_LEN; i++) begin
         if (step == STEP_W'(i)) prefix_hit = pre_vec[i];
      end
   end

   assign first_hit = pre_vec[0];
   assign float_hit = |flt_vec;
endmodule

// File: rtl/asq_tracker.sv
module asq_tracker
   import asq_pkg::*;
#(
   parameter int unsigned STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_vld,
   input  logic              acc_wr,
   input  logic              inhibit,
   input  logic              prefix_hit,
   input  logic              first_hit,
   input  logic              cmd_any,
   output logic [STEP_W-1:0] step,
   output logic              at_last,
   output logic              rd_ok,
   output logic              fire
);
   localparam logic [STEP_W-1:0] LAST    = STEP_W'(PREFIX_LEN);
   localparam logic [STEP_W-1:0] RESTART = STEP_W'(1);

   logic [STEP_W-1:0] step_q;

   assign step    = step_q;
   assign at_last = (step_q == LAST);
   assign rd_ok   = acc_vld && !acc_wr && !inhibit;
   assign fire    = rd_ok && at_last && cmd_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (inhibit) begin
         step_q <= '0;
      end else if (acc_vld) begin
         if (acc_wr)                 step_q <= '0;
         else if (fire)              step_q <= '0;
         else if (!at_last && prefix_hit) step_q <= step_q + RESTART;
         else if (first_hit)         step_q <= RESTART;
         else                        step_q <= '0;
      end
   end
endmodule

// File: rtl/asq_pulse.sv
module asq_pulse #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [WIDTH-1:0] sel,
   output logic [WIDTH-1:0] pulse
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse[i] <= 1'b0;
         else        pulse[i] <= fire && sel[i];
      end
   end
endmodule

// File: rtl/asq_cmd_detect.sv
module asq_cmd_detect
   import asq_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned CMP_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_vld,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              inhibit,
   output logic              cmd_store,
   output logic              cmd_recall,
   output logic              cmd_autosave_off,
   output logic              cmd_autosave_on,
   output logic              dq_float
);
   localparam int unsigned STEP_W = $clog2(PREFIX_LEN + 1);

   if (CMP_W > ADDR_W || CMP_W > 16 || CMP_W < 14) begin : g_bad_cmp
      $error("asq_cmd_detect: CMP_W must be 14..16 and not exceed ADDR_W");
   end

   logic [STEP_W-1:0]  step;
   logic               prefix_hit, first_hit, float_hit;
   logic [NUM_CMD-1:0] cmd_hit, pulses;
   logic               at_last, rd_ok, fire;

   asq_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .STEP_W(STEP_W)) i_match (
      .addr(acc_addr), .step(step), .prefix_hit(prefix_hit),
      .first_hit(first_hit), .cmd_hit(cmd_hit), .float_hit(float_hit)
   );

   asq_tracker #(.STEP_W(STEP_W)) i_tracker (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
      .inhibit(inhibit), .prefix_hit(prefix_hit), .first_hit(first_hit),
      .cmd_any(|cmd_hit), .step(step), .at_last(at_last), .rd_ok(rd_ok),
      .fire(fire)
   );

   asq_pulse #(.WIDTH(NUM_CMD)) i_pulse (
      .clk(clk), .rst_n(rst_n), .fire(fire), .sel(cmd_hit), .pulse(pulses)
   );

   assign cmd_store        = pulses[CMD_STORE];
   assign cmd_recall       = pulses[CMD_RECALL];
   assign cmd_autosave_off = pulses[CMD_AS_OFF];
   assign cmd_autosave_on  = pulses[CMD_AS_ON];
   assign dq_float         = rd_ok && at_last && float_hit;
endmodule

// File: rtl/asq_chk.sv
module asq_chk
   import asq_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned CMP_W  = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_vld,
   input logic              acc_wr,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              inhibit,
   input logic              cmd_store,
   input logic              cmd_recall,
   input logic              cmd_autosave_off,
   input logic              cmd_autosave_on,
   input logic              dq_float
);
   localparam logic [15:0] ST_CODE = cmd_code(CMD_STORE);
   localparam logic [15:0] RC_CODE = cmd_code(CMD_RECALL);

   logic any_cmd;
   assign any_cmd = cmd_store | cmd_recall | cmd_autosave_off | cmd_autosave_on;

   // R2
   one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_store, cmd_recall, cmd_autosave_off, cmd_autosave_on}));

   // R1
   cmd_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld && !acc_wr && !inhibit && dq_float |=> (cmd_store || cmd_recall));

   // R2
   store_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) || !cmd_store || $past(acc_addr[CMP_W-1:0]) == ST_CODE[CMP_W-1:0]);

   // R2
   recall_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) || !cmd_recall || $past(acc_addr[CMP_W-1:0]) == RC_CODE[CMP_W-1:0]);

   // R4
   write_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld && acc_wr |=> !any_cmd);

   // R6
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_cmd |=> !any_cmd);

   // R7
   float_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_float |-> acc_vld && !acc_wr && !inhibit);

   // R8
   inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |=> !any_cmd);
endmodule

bind asq_cmd_detect asq_chk #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
   .acc_addr(acc_addr), .inhibit(inhibit), .cmd_store(cmd_store),
   .cmd_recall(cmd_recall), .cmd_autosave_off(cmd_autosave_off),
   .cmd_autosave_on(cmd_autosave_on), .dq_float(dq_float)
);

// File: tb/test_asq_cmd_detect.sv
`timescale 1ns/1ps
module test_asq_cmd_detect;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_vld = 1'b0;
   logic        acc_wr = 1'b0;
   logic [16:0] acc_addr = '0;
   logic        inhibit = 1'b0;
   logic        cmd_store, cmd_recall, cmd_autosave_off, cmd_autosave_on, dq_float;

   int    n_chk = 0;
   int    n_bad = 0;
   int    m_step = 0;
   logic  done = 1'b0;
   logic [3:0] exp_pulse = '0;
   string tag = "R9";

   always #2.5 clk = ~clk;

   asq_cmd_detect i_asq_cmd_detect (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .inhibit(inhibit), .cmd_store(cmd_store),
      .cmd_recall(cmd_recall), .cmd_autosave_off(cmd_autosave_off),
      .cmd_autosave_on(cmd_autosave_on), .dq_float(dq_float)
   );

   function automatic logic [13:0] pre(input int i);
      case (i)
         0: return 14'h0E38;
         1: return 14'h31C7;
         2: return 14'h03E0;
         3: return 14'h3C1F;
         default: return 14'h303F;
      endcase
   endfunction

   // pulse vector order: store, recall, autosave off, autosave on
   function automatic logic [13:0] code(input int c);
      case (c)
         0: return 14'h0FC0;
         1: return 14'h0C63;
         2: return 14'h0B45;
         default: return 14'h0B46;
      endcase
   endfunction

   task automatic check(input string t, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
      end
   endtask

   task automatic model(input logic v, input logic w, input logic [16:0] a,
                        input logic inh, output logic [3:0] p, output logic f);
      logic [13:0] k;
      k = a[13:0];
      p = '0;
      f = 1'b0;
      if (inh) m_step = 0;
      else if (v) begin
         if (w) m_step = 0;
         else if (m_step == 5) begin
            for (int c = 0; c < 4; c++) if (k == code(c)) p[c] = 1'b1;
            f = p[0] | p[1];
            if (p != 0) m_step = 0;
            else m_step = (k == pre(0)) ? 1 : 0;
         end else if (k == pre(m_step)) m_step++;
         else m_step = (k == pre(0)) ? 1 : 0;
      end
   endtask

   task automatic acc(input logic v, input logic w, input logic [16:0] a, input logic inh);
      logic [3:0] ep;
      logic       ef;
      @(negedge clk);
      check({tag, " pulses (R1)"},
            {cmd_autosave_on, cmd_autosave_off, cmd_recall, cmd_store}, exp_pulse);
      acc_vld = v; acc_wr = w; acc_addr = a; inhibit = inh;
      model(v, w, a, inh, ep, ef);
      #1;
      check({tag, " float (R7)"}, {3'b0, dq_float}, {3'b0, ef});
      exp_pulse = ep;
   endtask

   function automatic logic [16:0] mk(input logic [13:0] k);
      return {3'($urandom), k};
   endfunction

   task automatic rd(input logic [13:0] k);
      acc(1'b1, 1'b0, mk(k), 1'b0);
   endtask

   task automatic prefix(input int upto);
      for (int i = 0; i < upto; i++) rd(pre(i));
   endtask

   task automatic idle();
      acc(1'b0, 1'b0, '0, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0000_5eed));
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 reset", {cmd_autosave_on, cmd_autosave_off, cmd_recall, cmd_store, dq_float}[3:0], 4'h0);
      check("R9 reset float", {3'b0, dq_float}, 4'h0);
      rst_n = 1'b1;
      idle();

      // R1 R2 R3 each command with random high bits
      for (int c = 0; c < 4; c++) begin
         tag = "R2";
         prefix(5); rd(code(c)); idle();
      end
      // R6 repeat only the sixth read
      tag = "R6";
      prefix(5); rd(code(0)); rd(code(0)); idle();
      // R4 write inside sequence
      tag = "R4";
      prefix(3); acc(1'b1, 1'b1, mk(pre(3)), 1'b0); rd(pre(3)); rd(pre(4)); rd(code(1)); idle();
      // R5 mismatch aborts, restart on first prefix
      tag = "R5";
      prefix(2); rd(14'h1234); rd(pre(2)); rd(pre(3)); rd(pre(4)); rd(code(2)); idle();
      prefix(4); prefix(5); rd(code(3)); idle();
      prefix(5); rd(pre(0)); prefix(5); idle();
      // R10 idle gaps keep progress
      tag = "R10";
      prefix(2); idle(); idle(); rd(pre(2)); idle(); rd(pre(3)); rd(pre(4)); idle(); rd(code(1)); idle();
      // R8 inhibit resets and blocks
      tag = "R8";
      prefix(5); acc(1'b1, 1'b0, mk(code(0)), 1'b1); rd(code(0)); idle();
      prefix(3); acc(1'b0, 1'b0, '0, 1'b1); rd(pre(3)); rd(pre(4)); rd(code(0)); idle();
      // R3 high bits all set
      tag = "R3";
      for (int i = 0; i < 5; i++) acc(1'b1, 1'b0, {3'b111, pre(i)}, 1'b0);
      acc(1'b1, 1'b0, {3'b101, code(0)}, 1'b0); idle();

      // random phase
      tag = "R1 random";
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom % 100);
         if (r < 70) begin
            if (m_step < 5) rd(pre(m_step));
            else rd(code(int'($urandom % 4)));
         end else if (r < 78) acc(1'b1, 1'b1, mk(pre(m_step % 5)), 1'b0);
         else if (r < 85) idle();
         else if (r < 88) acc(1'($urandom), 1'($urandom), mk(pre(m_step % 5)), 1'b1);
         else if (r < 94) rd(pre(0));
         else rd(14'($urandom));
      end
      idle(); idle();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule